// File: doc/BRIEF.md
# Recursive Seven-Stage Sigma-Delta Modulator

This block is the digital core of a high-resolution oversampled DAC. Once per modulator sample it accepts a signed input word. It runs that word through a chain of seven second-order noise-shaping stages and drives an array of unit elements. Each stage quantizes to one of six levels, meaning zero to five of its five unit elements are switched on. The analog side weights the stages 1, 3, 9, 27, 81, 243 and 729 and adds them with no digital correction.

Only the first stage sees the signal. Each later stage takes the noise-shaped residual of the stage before it. That residual is the quantized value minus the previous input, scaled down by three to the next stage's step. The later stage re-modulates this residual, so that the weighted sum cancels it and leaves only residue that is differenced once more. A 52-bit maximal-length shift register gives each stage one dither bit per sample. A rotating pointer in each stage picks which physical elements carry the code, so that element mismatch averages out.

A sample is registered in one clock. The codes and element masks of all stages appear together one clock later.

Top module: `rsdm_top`

## Requirements
- R1: A clock with `smp_vld` high produces an `out_vld` pulse exactly two clocks later. `code_o` and `mask_o` change only in a cycle where `out_vld` is high.
- R2: Field k of `code_o` (bits 3k+2..3k, stage 0 carries the signal) is the number of enabled elements of stage k, always in 0..5.
- R3: Field k of `mask_o` (bits 5k+4..5k, bit i = element i) has exactly as many ones as field k of `code_o`.
- R4: Each stage enables its elements starting at a pointer and continuing consecutively modulo 5. After each sample the pointer advances by the code modulo 5. The pointer is 0 after reset.
- R5: For a constant in-range input d, the mean of the stage-0 code over many samples is 2.5 + 2.5·d/2^23.
- R6: Stages 1 to 6 receive no signal, only residual, so their mean code stays at 2.5 for any constant in-range input.
- R7: The input is clamped to ±floor(2^23·63/100) = ±5284823. A larger magnitude yields exactly the output stream of the limit value, and the stage-0 mean at the limit is 4.075.
- R8: The dither register (feedback from bits 52 and 49) is loaded with a fixed nonzero seed at reset, advances once per sample and never reaches zero. Identical input streams after reset therefore give identical outputs.
- R9: A synchronous active-low reset clears all integrators, codes, masks, pointers and `out_vld`, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Strobe: new input sample present |
| smp_data | input | 24 | Signed input sample, full scale ±2^23 |
| out_vld | output | 1 | One-cycle pulse: new codes and masks valid |
| code_o | output | 21 | Seven 3-bit stage codes, stage 0 in the low bits |
| mask_o | output | 35 | Seven 5-bit element masks, stage 0 in the low bits |

## Verification
The bound checker checks the following on every cycle: the two-clock strobe-to-pulse timing, that the outputs hold between pulses, the code range, agreement between mask population and code, pointer bounds, and that the dither register is never zero. Several behaviours can only be shown by the bench's scenarios: the exact rotation order of the selected elements, the tracking of the input by the first-stage mean, the zero mean of the later stages, clamp equivalence at and beyond the depth limit, and repeatable output after a mid-run reset.

// File: rtl/rsdm_pkg.sv
// Shared constants of the recursive modulator: dither register shape and seed.
// Assumes the dither register is 52 bits wide with maximal-length feedback.
package rsdm_pkg;
    localparam int          LFSR_W    = 52;
    localparam int          TAP_HI    = 52;
    localparam int          TAP_LO    = 49;
    localparam logic [51:0] LFSR_SEED = 52'h5_A3C9_1E7B_D024;
    localparam int          DIV_SH    = 16;   // reciprocal-of-three precision
endpackage

// File: rtl/rsdm_lfsr.sv
// Dither generator: Fibonacci shift register with feedback from TAP_HI and
// TAP_LO. One step per enable. Stage k gets bit k*STRIDE, so every stage
// takes a distinct tap. Assumes (NB-1)*STRIDE < LW and a nonzero SEED.
module rsdm_lfsr #(
    parameter int          LW     = rsdm_pkg::LFSR_W,
    parameter int          NB     = 7,
    parameter int          STRIDE = 7,
    parameter logic [LW-1:0] SEED = rsdm_pkg::LFSR_SEED
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [NB-1:0] dith,
    output logic [LW-1:0] state
);
    logic fb;

    // feedback bit from the two maximal-length taps
    always_comb fb = state[rsdm_pkg::TAP_HI-1] ^ state[rsdm_pkg::TAP_LO-1];

    // shift once per sample, reload seed on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  state <= SEED;
        else if (en) state <= {state[LW-2:0], fb};
    end

    // one distinct tap per stage
    for (genvar k = 0; k < NB; k++) begin : g_tap
        assign dith[k] = state[k*STRIDE];
    end
endmodule

// File: rtl/rsdm_stage.sv
// One second-order noise-shaping stage with a (NEL+1)-level quantizer.
// Fixed point: 1.0 = one element step = 2^F. Loop: v = i2 + dither,
// level = clamp(floor(v)+OFS), i1 += x - q, i2 += i1' - q (saturating).
// This gives q = x*z^-1 + (1-z^-1)^2 e. The hand-off x_out = -(q - x_prev)/3
// feeds the next stage, which is weighted three times heavier.
// Assumes NEL is odd, so the thresholds sit on whole steps.
module rsdm_stage #(
    parameter int F   = 23,
    parameter int IW  = 28,
    parameter int NEL = 5,
    parameter int CW  = 3,
    parameter int DSH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [IW-1:0] x_in,
    input  logic                 dith,
    output logic        [CW-1:0] lvl,
    output logic        [CW-1:0] code,
    output logic signed [IW-1:0] x_out
);
    localparam int WW  = IW + 4;
    localparam int RS  = rsdm_pkg::DIV_SH;
    localparam int OFS = (NEL + 1) / 2;
    localparam logic signed [WW-1:0] SAT_HI = {{(WW-IW+1){1'b0}}, {(IW-1){1'b1}}};
    localparam logic signed [WW-1:0] SAT_LO = -SAT_HI;
    localparam logic signed [WW-1:0] ONE_W  = {{(WW-1){1'b0}}, 1'b1};
    localparam logic signed [WW-1:0] DAMP   = ONE_W <<< (F - DSH);
    localparam logic signed [WW-1:0] OFSW   = WW'(OFS);
    localparam logic signed [WW-1:0] NELW   = WW'(NEL);
    localparam logic signed [RS+1:0] KDIV   = (RS+2)'(((2**RS) + 2) / 3);

    logic signed [IW-1:0] i1, i2, xprev;
    logic signed [IW-1:0] i1n, i2n;
    logic signed [WW-1:0] xw, i1w, i2w, xpw, v, t, lw, qv, s1, s2, res;
    logic signed [WW+RS+1:0] prod;

    function automatic logic signed [IW-1:0] sat(input logic signed [WW-1:0] a);
        if (a > SAT_HI)      return IW'(SAT_HI);
        else if (a < SAT_LO) return IW'(SAT_LO);
        else                 return IW'(a);
    endfunction

    function automatic logic signed [WW-1:0] sx(input logic signed [IW-1:0] a);
        return {{(WW-IW){a[IW-1]}}, a};
    endfunction

    // quantizer, loop-filter update and residual hand-off
    always_comb begin
        xw  = sx(x_in);
        i1w = sx(i1);
        i2w = sx(i2);
        xpw = sx(xprev);
        v   = i2w + (dith ? DAMP : -DAMP);
        t   = (v >>> F) + OFSW;
        if (t < 0)          lvl = '0;
        else if (t > NELW)  lvl = CW'(NEL);
        else                lvl = CW'(t);
        lw  = $signed({{(WW-CW){1'b0}}, lvl});
        qv  = ((lw <<< 1) - NELW) <<< (F - 1);
        s1  = i1w + xw - qv;
        i1n = sat(s1);
        s2  = i2w + sx(i1n) - qv;
        i2n = sat(s2);
        res = qv - xpw;
        prod  = res * KDIV;
        x_out = IW'(-(prod >>> RS));
    end

    // state and code register, one step per sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i1 <= '0; i2 <= '0; xprev <= '0; code <= '0;
        end else if (en) begin
            i1 <= i1n; i2 <= i2n; xprev <= x_in; code <= lvl;
        end
    end
endmodule

// File: rtl/rsdm_dwa.sv
// Rotating element selector: enables lvl consecutive elements starting at
// the pointer (wrapping modulo NEL), then advances the pointer by lvl.
// Assumes lvl <= NEL.
module rsdm_dwa #(
    parameter int NEL = 5,
    parameter int CW  = 3,
    parameter int PW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [CW-1:0]  lvl,
    output logic [NEL-1:0] mask,
    output logic [PW-1:0]  ptr
);
    logic [NEL-1:0] mask_n;
    logic [PW-1:0]  ptr_n;

    // element j is on when its distance past the pointer is below lvl
    always_comb begin
        for (int j = 0; j < NEL; j++) begin
            int d;
            d = j - int'(ptr);
            if (d < 0) d = d + NEL;
            mask_n[j] = (d < int'(lvl));
        end
    end

    // pointer advance modulo NEL
    always_comb begin
        int s;
        s = int'(ptr) + int'(lvl);
        if (s >= NEL) s = s - NEL;
        ptr_n = PW'(s);
    end

    // register mask and pointer once per sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0; ptr <= '0;
        end else if (en) begin
            mask <= mask_n; ptr <= ptr_n;
        end
    end
endmodule

// File: rtl/rsdm_top.sv
// Recursive cascaded modulator top. Cycle 1 registers the clamped sample.
// Cycle 2 runs the whole stage chain combinationally and registers all
// codes and masks together. Assumes smp_vld marks one sample per pulse.
module rsdm_top #(
    parameter int W         = 24,
    parameter int NS        = 7,
    parameter int NEL       = 5,
    parameter int DEPTH_PCT = 63,
    parameter int DITH_SH   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_vld,
    input  logic signed [W-1:0]    smp_data,
    output logic                   out_vld,
    output logic [NS*3-1:0]        code_o,
    output logic [NS*NEL-1:0]      mask_o
);
    localparam int CW = $clog2(NEL + 1);
    localparam int PW = $clog2(NEL);
    localparam int F  = W - 1;
    localparam int IW = F + 5;
    localparam int LW = rsdm_pkg::LFSR_W;
    localparam longint LIML = ((longint'(1) <<< (W - 1)) * DEPTH_PCT) / 100;
    localparam logic signed [W-1:0]  LIM  = W'(LIML);
    localparam logic signed [W-1:0]  NLIM = -LIM;
    localparam logic signed [IW-1:0] NELI = IW'(NEL);

    logic signed [W-1:0]  in_q;
    logic                 go;
    logic signed [IW-1:0] xe;
    logic signed [IW-1:0] xs [NS+1];
    logic [NS-1:0]        dith;
    logic [LW-1:0]        lfsr_st;
    logic [CW-1:0]        lvl_w [NS];
    logic [NS*PW-1:0]     ptr_all;

    // register the depth-clamped sample and the two-step valid chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0; go <= 1'b0; out_vld <= 1'b0;
        end else begin
            go      <= smp_vld;
            out_vld <= go;
            if (smp_vld) begin
                if (smp_data > LIM)       in_q <= LIM;
                else if (smp_data < NLIM) in_q <= NLIM;
                else                      in_q <= smp_data;
            end
        end
    end

    // map full scale to plus/minus half the stage-0 element range
    always_comb begin
        xe    = {{(IW-W){in_q[W-1]}}, in_q};
        xs[0] = IW'((xe * NELI) >>> 1);
    end

    rsdm_lfsr #(.LW(LW), .NB(NS), .STRIDE(7)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .en(go), .dith(dith), .state(lfsr_st)
    );

    for (genvar k = 0; k < NS; k++) begin : g_stage
        rsdm_stage #(.F(F), .IW(IW), .NEL(NEL), .CW(CW), .DSH(DITH_SH)) u_st (
            .clk(clk), .rst_n(rst_n), .en(go), .x_in(xs[k]), .dith(dith[k]),
            .lvl(lvl_w[k]), .code(code_o[k*3 +: 3]), .x_out(xs[k+1])
        );
        rsdm_dwa #(.NEL(NEL), .CW(CW), .PW(PW)) u_dwa (
            .clk(clk), .rst_n(rst_n), .en(go), .lvl(lvl_w[k]),
            .mask(mask_o[k*NEL +: NEL]), .ptr(ptr_all[k*PW +: PW])
        );
    end
endmodule

// File: rtl/rsdm_chk.sv
// Checker for rsdm_top: output timing, code range, mask/code agreement,
// pointer bounds and dither register health. Bound into every rsdm_top.
module rsdm_chk #(
    parameter int NS  = 7,
    parameter int NEL = 5,
    parameter int PW  = 3,
    parameter int LW  = 52
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_vld,
    input logic              out_vld,
    input logic [NS*3-1:0]   code_o,
    input logic [NS*NEL-1:0] mask_o,
    input logic [NS*PW-1:0]  ptr_all,
    input logic [LW-1:0]     lfsr_st
);
    // R1
    strobe_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> ##2 out_vld);
    // R1
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(smp_vld, 2));
    // R1
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> ($stable(code_o) && $stable(mask_o)));
    // R8
    dither_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_st != '0);

    for (genvar k = 0; k < NS; k++) begin : g_st
        // R2
        code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            code_o[k*3 +: 3] <= 3'(NEL));
        // R3
        mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(mask_o[k*NEL +: NEL]) == int'(code_o[k*3 +: 3]));
        // R4
        ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(ptr_all[k*PW +: PW]) < NEL);
    end
endmodule

bind rsdm_top rsdm_chk #(.NS(NS), .NEL(NEL), .PW(PW), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .out_vld(out_vld),
    .code_o(code_o), .mask_o(mask_o), .ptr_all(ptr_all), .lfsr_st(lfsr_st)
);

// File: tb/tb_rsdm_top.sv
`timescale 1ns/1ps
module tb_rsdm_top;
    localparam int W = 24, NS = 7, NEL = 5;
    localparam int LIMV = 5284823;

    logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0;
    logic signed [W-1:0] smp_data = '0;
    logic out_vld;
    logic [NS*3-1:0]   code_o;
    logic [NS*NEL-1:0] mask_o;

    rsdm_top dut (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
                  .out_vld(out_vld), .code_o(code_o), .mask_o(mask_o));

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int ptr_m [NS];
    real sums [NS];
    int nsmp, lat_err, dwa_err, rng_err, hold_err;
    longint unsigned sig;

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin n_fail++; $display("FAIL %s", msg); end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; smp_vld = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NS; k++) ptr_m[k] = 0;
    endtask

    task automatic clear_stats();
        for (int k = 0; k < NS; k++) sums[k] = 0.0;
        nsmp = 0; lat_err = 0; dwa_err = 0; rng_err = 0; hold_err = 0; sig = 64'd1;
    endtask

    // one sample: timing, rotation model, range and hold all checked here
    task automatic send_one(input logic signed [W-1:0] d);
        logic [NS*3-1:0] c_cap;
        logic [NS*NEL-1:0] m_cap;
        @(negedge clk); smp_vld = 1'b1; smp_data = d;
        @(negedge clk); smp_vld = 1'b0;
        if (out_vld !== 1'b0) lat_err++;
        @(negedge clk);
        if (out_vld !== 1'b1) lat_err++;
        c_cap = code_o; m_cap = mask_o;
        for (int k = 0; k < NS; k++) begin
            int c;
            logic [NEL-1:0] em;
            c = int'(c_cap[k*3 +: 3]);
            if (c > NEL) rng_err++;
            em = '0;
            for (int j = 0; j < c && j < NEL; j++) em[(ptr_m[k] + j) % NEL] = 1'b1;
            if (m_cap[k*NEL +: NEL] !== em) dwa_err++;
            ptr_m[k] = (ptr_m[k] + c) % NEL;
            sums[k] = sums[k] + real'(c);
        end
        sig = {sig[58:0], sig[63:59]} ^ {8'd0, m_cap, c_cap};
        nsmp++;
        @(negedge clk);
        if (out_vld !== 1'b0 || code_o !== c_cap || mask_o !== m_cap) hold_err++;
    endtask

    task automatic run_const(input logic signed [W-1:0] d, input int n);
        clear_stats();
        for (int i = 0; i < n; i++) send_one(d);
    endtask

    task automatic common_checks(input string tag);
        check(lat_err == 0, $sformatf("R1 %s: timing errors actual %0d expected 0", tag, lat_err));
        check(hold_err == 0, $sformatf("R1 %s: hold errors actual %0d expected 0", tag, hold_err));
        check(rng_err == 0, $sformatf("R2 %s: code range errors actual %0d expected 0", tag, rng_err));
        check(dwa_err == 0, $sformatf("R3 R4 %s: mask errors actual %0d expected 0", tag, dwa_err));
    endtask

    // R9: outputs cleared while reset is held
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_vld === 1'b0 && code_o === '0 && mask_o === '0,
              $sformatf("R9 reset state: actual vld=%0b code=%h mask=%h expected 0 0 0",
                        out_vld, code_o, mask_o));
        do_reset();
    endtask

    // R5, R6: stage-0 mean tracks input, later stages sit at mid-scale
    task automatic t_track(input logic signed [W-1:0] d);
        real m0, e0, worst;
        do_reset();
        run_const(d, 512);
        m0 = sums[0] / nsmp;
        e0 = 2.5 + 2.5 * real'(d) / 8388608.0;
        check(m0 > e0 - 0.03 && m0 < e0 + 0.03,
              $sformatf("R5 input %0d: stage0 mean actual %f expected %f", d, m0, e0));
        worst = 2.5;
        for (int k = 1; k < NS; k++) begin
            real mk;
            mk = sums[k] / nsmp;
            if ((mk - 2.5) * (mk - 2.5) > (worst - 2.5) * (worst - 2.5)) worst = mk;
        end
        check(worst > 2.4 && worst < 2.6,
              $sformatf("R6 input %0d: worst later-stage mean actual %f expected 2.5", d, worst));
        common_checks("track");
    endtask

    // R7: beyond-limit input equals the limit; mean at limit
    task automatic t_clamp(input logic signed [W-1:0] lim, input logic signed [W-1:0] over);
        longint unsigned s_lim;
        real m0, e0;
        do_reset(); run_const(lim, 256); s_lim = sig;
        m0 = sums[0] / nsmp;
        e0 = 2.5 + 2.5 * real'(lim) / 8388608.0;
        check(m0 > e0 - 0.04 && m0 < e0 + 0.04,
              $sformatf("R7 limit %0d: stage0 mean actual %f expected %f", lim, m0, e0));
        do_reset(); run_const(over, 256);
        check(sig == s_lim, $sformatf("R7 over %0d: signature actual %h expected %h", over, sig, s_lim));
        common_checks("clamp");
    endtask

    // R8, R9: mid-run reset restarts dither, pointers and loop state
    task automatic t_repeat();
        longint unsigned s_a;
        do_reset(); clear_stats();
        for (int i = 0; i < 150; i++) send_one(W'((i * 40009) % 3000000 - 1500000));
        s_a = sig;
        for (int i = 0; i < 37; i++) send_one(W'(2000000));
        do_reset(); clear_stats();
        for (int i = 0; i < 150; i++) send_one(W'((i * 40009) % 3000000 - 1500000));
        check(sig == s_a, $sformatf("R8 R9 repeat after reset: signature actual %h expected %h", sig, s_a));
        common_checks("repeat");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1; n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_track(W'(0));
        t_track(W'(2097152));
        t_track(-W'(4194304));
        t_clamp(W'(LIMV), W'(8388607));
        t_clamp(-W'(LIMV), -W'(8388608));
        t_repeat();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule